// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one compare channel beside a free-running 16-bit timer. It keeps a 16-bit compare value and checks it against the timer count on every clock. When the two are equal the block drives its compare output pin and sets an interrupt request flag. A mode bit picks how the pin reacts.

- **Automatic mode.** The pin goes high on a match and low on timer overflow.
- **Software mode.** On a match the pin takes a level that software chose in advance. Overflow leaves the pin alone.

Software loads the compare value through a byte-wide write port, one byte at a time. In automatic mode the comparison does not use the written register. It uses a shadow latch that copies the register only at timer overflow. Software can therefore rewrite the value at any moment without losing or duplicating a match inside the current timer period.

The pin is driven by a two-state machine.

States:
- `PIN_LOW`: the pin is low.
- `PIN_HIGH`: the pin is high.

Transitions:
- `RAISE_ON_MATCH` (`PIN_LOW` to `PIN_HIGH`):
  - in automatic mode, on a match with no overflow in that cycle;
  - in software mode, on a match while the next-level bit is 1.
- `DROP_ON_OVERFLOW` (`PIN_HIGH` to `PIN_LOW`): automatic mode, any overflow.
- `DROP_ON_MATCH` (`PIN_HIGH` to `PIN_LOW`): software mode, a match while the next-level bit is 0.
- `HOLD`: every other case, including every cycle with no match and no qualifying overflow.

Top module: `cmp_channel`

## Requirements
- R1: After reset the pin is low, the interrupt flag is clear, the mode is automatic, the next-level bit is 0, and both the compare register and the shadow latch hold 0.
- R2: A match is exact 16-bit equality between `timer_val` and the active compare value. Each match sets the interrupt flag at the next clock edge.
- R3: The interrupt flag stays set until a write with bit 0 = 1 at offset 3. If a clear and a match fall in the same cycle, the flag stays set.
- R4: In automatic mode a match without overflow makes the pin high at the next edge.
- R5: In automatic mode an overflow makes the pin low at the next edge. This holds even when a match occurs in the same cycle.
- R6: In automatic mode the active compare value is the shadow latch. The latch copies the full compare register only at an edge where `timer_ovf` is 1. Writes between overflows do not change which timer value matches.
- R7: In software mode a match loads the next-level bit into the pin at the next edge.
- R8: In software mode `timer_ovf` has no effect on the pin.
- R9: In software mode the active compare value is the compare register itself, including a byte written at the edge just before.
- R10: Write map:
  - offset 0 loads compare bits 7:0;
  - offset 1 loads compare bits 15:8;
  - offset 2 loads the control byte, where bit 0 is the mode (0 automatic, 1 software) and bit 1 is the next level;
  - offset 3 with bit 0 set clears the interrupt flag.
  A write takes effect at the edge of the cycle it is presented in.
- R11: In a cycle without a match, and without overflow in automatic mode, the pin keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Current count of the free-running timer |
| timer_ovf | input | 1 | High for the one cycle in which the timer wraps |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Write offset |
| wr_data | input | 8 | Write data byte |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request flag |

## Verification
The assertions check every cycle that the pin follows the state-machine rules. In automatic mode they cover overflow priority, rising on a match, and holding in idle cycles. In software mode they cover ignoring overflow and taking the next-level bit. They also check that the interrupt flag sets on a match and is sticky, and that the shadow latch moves only at overflow and then copies the register.

Only the bench scenarios can show the behaviour at the ports over a sequence. Examples are a compare value written between overflows that has no effect until the next wrap, a byte-wise rewrite that is live at once in software mode, and a clear that collides with a match.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    typedef enum logic {
        MODE_AUTO = 1'b0,
        MODE_SOFT = 1'b1
    } cmp_mode_e;

    // bit positions inside the control byte
    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_NEXT_BIT = 1;
    localparam int CLR_IRQ_BIT   = 0;

endpackage

// File: rtl/cmpch_regs.sv
module cmpch_regs
    import cmpch_pkg::*;
#(
    parameter int TW = 16,
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          timer_ovf,
    output logic [TW-1:0] cmp_reg,
    output logic [TW-1:0] cmp_latch,
    output cmp_mode_e     mode,
    output logic          next_lvl,
    output logic          irq_clr
);
    localparam int NBYTES   = TW / DW;
    localparam int OFF_CTRL = NBYTES;
    localparam int OFF_CLR  = NBYTES + 1;

    // one write lane per compare byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_reg[g*DW +: DW] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                cmp_reg[g*DW +: DW] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_AUTO;
            next_lvl <= 1'b0;
        end else if (wr_en && (wr_addr == AW'(OFF_CTRL))) begin
            mode     <= cmp_mode_e'(wr_data[CTRL_MODE_BIT]);
            next_lvl <= wr_data[CTRL_NEXT_BIT];
        end
    end

    // shadow latch: full-width copy only at overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_latch <= '0;
        end else if (timer_ovf) begin
            cmp_latch <= cmp_reg;
        end
    end

    assign irq_clr = wr_en && (wr_addr == AW'(OFF_CLR)) && wr_data[CLR_IRQ_BIT];

    logic unused_data_bits;
    assign unused_data_bits = ^wr_data;

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_ovf |=> $stable(cmp_latch))
        else $error("R6 latch changed without overflow");

    a_r6_latch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        timer_ovf |=> cmp_latch == $past(cmp_reg))
        else $error("R6 latch not loaded at overflow");

endmodule

// File: rtl/cmpch_match.sv
module cmpch_match
    import cmpch_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] cmp_reg,
    input  logic [TW-1:0] cmp_latch,
    input  cmp_mode_e     mode,
    output logic          match
);
    logic [TW-1:0] active_val;

    always_comb begin
        unique case (mode)
            MODE_AUTO: active_val = cmp_latch;
            MODE_SOFT: active_val = cmp_reg;
            default:   active_val = cmp_latch;
        endcase
    end

    assign match = (timer_val == active_val);

endmodule

// File: rtl/cmpch_out_fsm.sv
module cmpch_out_fsm
    import cmpch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      match,
    input  logic      timer_ovf,
    input  cmp_mode_e mode,
    input  logic      next_lvl,
    input  logic      irq_clr,
    output logic      pin,
    output logic      irq
);
    pin_state_e state_q, state_d;
    logic       irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW: begin
                if (mode == MODE_AUTO) begin
                    if (match && !timer_ovf) state_d = PIN_HIGH;   // RAISE_ON_MATCH
                end else begin
                    if (match && next_lvl) state_d = PIN_HIGH;     // RAISE_ON_MATCH
                end
            end
            PIN_HIGH: begin
                if (mode == MODE_AUTO) begin
                    if (timer_ovf) state_d = PIN_LOW;              // DROP_ON_OVERFLOW
                end else begin
                    if (match && !next_lvl) state_d = PIN_LOW;     // DROP_ON_MATCH
                end
            end
            default: state_d = PIN_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (match)   irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign pin = (state_q == PIN_HIGH);
    assign irq = irq_q;

    a_r2_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq)
        else $error("R2 flag not set after match");

    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq)
        else $error("R3 flag dropped without clear");

    a_r4_auto_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && match && !timer_ovf) |=> pin)
        else $error("R4 pin not high after match");

    a_r5_auto_ovf_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && timer_ovf) |=> !pin)
        else $error("R5 pin not low after overflow");

    a_r7_soft_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOFT && match) |=> pin == $past(next_lvl))
        else $error("R7 pin did not take next level");

    a_r8_soft_ovf_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOFT && !match) |=> $stable(pin))
        else $error("R8 pin moved without match in software mode");

    a_r11_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && !match && !timer_ovf) |=> $stable(pin))
        else $error("R11 pin moved in idle cycle");

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmpch_pkg::*;
#(
    parameter int TW = 16,
    parameter int DW = 8,
    parameter int AW = $clog2(TW / DW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          timer_ovf,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          cmp_out,
    output logic          irq
);
    logic [TW-1:0] cmp_reg;
    logic [TW-1:0] cmp_latch;
    cmp_mode_e     mode;
    logic          next_lvl;
    logic          irq_clr;
    logic          match;

    cmpch_regs #(.TW(TW), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .timer_ovf (timer_ovf),
        .cmp_reg   (cmp_reg),
        .cmp_latch (cmp_latch),
        .mode      (mode),
        .next_lvl  (next_lvl),
        .irq_clr   (irq_clr)
    );

    cmpch_match #(.TW(TW)) u_match (
        .timer_val (timer_val),
        .cmp_reg   (cmp_reg),
        .cmp_latch (cmp_latch),
        .mode      (mode),
        .match     (match)
    );

    cmpch_out_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .timer_ovf (timer_ovf),
        .mode      (mode),
        .next_lvl  (next_lvl),
        .irq_clr   (irq_clr),
        .pin       (cmp_out),
        .irq       (irq)
    );

endmodule

// File: tb/cmp_channel_bench.sv
module cmp_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'h0100;
    logic        timer_ovf = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cmp_out;
    logic        irq;

    always #5 clk = ~clk;

    cmp_channel u_cmp_channel (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .timer_ovf(timer_ovf),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_out(cmp_out), .irq(irq)
    );

    typedef struct {
        logic  pin;
        logic  irq;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    // reference model state
    logic [15:0] m_reg = '0, m_latch = '0;
    logic        m_mode = 0, m_next = 0, m_pin = 0, m_irq = 0;

    task automatic step(input logic [15:0] tv, input logic ovf,
                        input logic we, input logic [1:0] a, input logic [7:0] d,
                        input string tag);
        logic        hit;
        logic [15:0] nreg;
        exp_t        e;
        @(negedge clk);
        timer_val = tv; timer_ovf = ovf; wr_en = we; wr_addr = a; wr_data = d;
        hit = (tv == (m_mode ? m_reg : m_latch));
        if (!m_mode) begin
            if (ovf)      m_pin = 1'b0;
            else if (hit) m_pin = 1'b1;
        end else if (hit) begin
            m_pin = m_next;
        end
        if (hit) m_irq = 1'b1;
        else if (we && a == 2'd3 && d[0]) m_irq = 1'b0;
        nreg = m_reg;
        if (we && a == 2'd0) nreg[7:0] = d;
        if (we && a == 2'd1) nreg[15:8] = d;
        if (ovf) m_latch = m_reg;
        if (we && a == 2'd2) begin m_mode = d[0]; m_next = d[1]; end
        m_reg = nreg;
        e.pin = m_pin; e.irq = m_irq; e.tag = tag;
        expq.push_back(e);
    endtask

    // monitor: samples after each edge, compares against the scoreboard head
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (expq.size() > 0) begin
            e = expq.pop_front();
            n_checks++;
            if (cmp_out !== e.pin || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: pin/irq actual %b/%b expected %b/%b",
                         e.tag, cmp_out, irq, e.pin, e.irq);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (cmp_out !== 1'b0 || irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: pin/irq actual %b/%b expected 0/0", cmp_out, irq);
        end
        rst_n = 1'b1;
        // R10 byte-wise write; R6 register not yet live in automatic mode
        step(16'h0100, 0, 1, 2'd0, 8'h34, "R10 low byte write");
        step(16'h0101, 0, 1, 2'd1, 8'h12, "R10 high byte write");
        step(16'h1234, 0, 0, 2'd0, 8'h00, "R6 written value not live before overflow");
        // R5 overflow beats a same-cycle latch match (latch 0 == timer 0); R2 flag set
        step(16'h0000, 1, 0, 2'd0, 8'h00, "R5 overflow priority, R2 flag");
        step(16'h0005, 0, 1, 2'd3, 8'h01, "R3 clear flag");
        step(16'h0006, 0, 0, 2'd0, 8'h00, "R3 flag stays clear");
        step(16'h1234, 0, 0, 2'd0, 8'h00, "R4 rise on latch match");
        step(16'h1235, 0, 0, 2'd0, 8'h00, "R11 hold high");
        step(16'h1236, 0, 1, 2'd3, 8'h00, "R3 write without bit0 keeps flag");
        step(16'h0000, 1, 0, 2'd0, 8'h00, "R5 overflow drops pin");
        step(16'h0001, 0, 1, 2'd3, 8'h01, "R3 clear");
        // R6 rewrite between overflows
        step(16'h0002, 0, 1, 2'd1, 8'h55, "R6 rewrite high byte");
        step(16'h5534, 0, 0, 2'd0, 8'h00, "R6 new value ignored");
        step(16'h1234, 0, 0, 2'd0, 8'h00, "R6 old latch still matches");
        step(16'h0000, 1, 0, 2'd0, 8'h00, "R6 overflow loads latch");
        step(16'h1234, 0, 1, 2'd3, 8'h01, "R6 old value gone, R3 clear");
        step(16'h5534, 0, 0, 2'd0, 8'h00, "R6 new value matches");
        step(16'h5533, 0, 0, 2'd0, 8'h00, "R11 hold");
        step(16'h0000, 1, 0, 2'd0, 8'h00, "R5 drop");
        // software mode
        step(16'h0010, 0, 1, 2'd2, 8'h03, "R10 control write soft next=1");
        step(16'h5534, 0, 1, 2'd3, 8'h01, "R7 level 1 on match, R3 match beats clear");
        step(16'h0000, 1, 0, 2'd0, 8'h00, "R8 overflow ignored");
        step(16'h0011, 0, 1, 2'd2, 8'h01, "R10 control next=0");
        step(16'h5534, 0, 0, 2'd0, 8'h00, "R7 level 0 on match");
        step(16'h0012, 0, 1, 2'd0, 8'h77, "R9 low byte rewrite");
        step(16'h5577, 0, 1, 2'd2, 8'h03, "R9 direct register match, next=1 queued");
        step(16'h5577, 0, 0, 2'd0, 8'h00, "R9 R7 direct match raises pin");
        step(16'h0000, 1, 1, 2'd3, 8'h01, "R8 overflow ignored, R3 clear");
        step(16'h0013, 0, 0, 2'd0, 8'h00, "R8 pin holds");
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule